// File: doc/BRIEF.md
# Lockable Sector Instruction Cache

This block places a small on-chip store between an instruction-fetch port and a slower external program memory. The store holds 1024 words of 24 bits, split into eight sectors of 128 consecutive words. Any sector can hold any 128-word-aligned region of the address space, because placement is fully associative. Each sector carries one tag, formed from the upper fetch-address bits, and one valid bit per word, so a sector fills word by word as the program touches it.

When a tag misses, the block reallocates the least recently used sector among those not locked. A lock mask, with one bit per sector, keeps chosen code resident. If every sector is locked, the miss is still served, but no sector is allocated. A flush input drops every valid bit at once.

With the cache-enable input low, the same array acts as plain program RAM. It is then loaded through a write port, and fetches read it directly with no external access.

Top module: `icache_lockable`

## Requirements
- R1: During reset, and after it, `fetch_rdy` is 1, `fetch_valid` is 0 and `ext_req` is 0.
- R2: In cache mode, a fetch whose word is valid in a resident sector raises `fetch_valid` in the next cycle with the stored word, and makes no external request.
- R3: A fetch that misses drops `fetch_rdy` and raises `ext_req`, with `ext_addr` equal to the fetch address. Both stay steady until `ext_ack`, for any latency. In the cycle after `ext_ack`, `fetch_valid` is 1 with the acknowledged word and `fetch_rdy` is 1 again.
- R4: A miss on an invalid word of a resident sector fills only that word. The words already valid in that sector keep hitting.
- R5: A miss whose tag matches no sector reallocates the least recently used unlocked sector and invalidates all of its words. Recency is refreshed whenever a sector is accessed or allocated.
- R6: A sector whose `lock_mask` bit is 1 is never reallocated, and it still serves hits. With all eight bits set, misses are served without allocation, so repeating the same fetch misses again.
- R7: A one-cycle `flush` pulse invalidates every sector, so the next fetch to any address misses.
- R8: When `flush` is high in the same cycle as `ext_ack`, the acknowledged word still reaches the fetch port, but it is not left valid in the store.
- R9: With `cache_en` at 0, `load_we` writes `load_data` at array index `load_addr`. A fetch then returns the word at index `fetch_addr[9:0]` in the next cycle, ignoring the upper address bits, with no external request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | 1: cache mode, 0: program-RAM mode |
| flush | input | 1 | Invalidate all sectors and words |
| lock_mask | input | 8 | Per-sector replacement lock |
| fetch_req | input | 1 | Fetch request, taken when fetch_rdy is 1 |
| fetch_addr | input | 16 | Fetch word address |
| fetch_rdy | output | 1 | Fetch port can take a request |
| fetch_valid | output | 1 | fetch_data holds the requested word |
| fetch_data | output | 24 | Returned instruction word |
| ext_req | output | 1 | External word read pending |
| ext_addr | output | 16 | External read address |
| ext_ack | input | 1 | External word present on ext_data |
| ext_data | input | 24 | External read data |
| load_we | input | 1 | Program-RAM write strobe (RAM mode only) |
| load_addr | input | 10 | Program-RAM write index |
| load_data | input | 24 | Program-RAM write data |

## Verification
A fill completing and a flush can land in the same clock edge. In that case the returned word must still reach the fetch port, while the invalidation must win over the word-valid update. The bench provokes this by having its external-memory model assert `flush` in the cycle it pulses `ext_ack`. It then checks that the delivered word is correct, and that an immediate refetch of the same address raises a fresh external request instead of hitting.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int DATA_W     = 24;
    localparam int ADDR_W     = 16;
    localparam int NUM_SECT   = 8;
    localparam int SECT_WORDS = 128;

    typedef enum logic {
        ST_IDLE,
        ST_FILL
    } fill_state_t;

    function automatic int idx_bits(input int sectors, input int words);
        return $clog2(sectors) + $clog2(words);
    endfunction
endpackage

// File: rtl/icache_store.sv
module icache_store #(
    parameter int DW    = 24,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/icache_tag_match.sv
module icache_tag_match #(
    parameter int NS  = 8,
    parameter int TW  = 9,
    localparam int SW = $clog2(NS)
) (
    input  logic [NS-1:0][TW-1:0] tags,
    input  logic [NS-1:0]         sect_valid,
    input  logic [TW-1:0]         look_tag,
    output logic [NS-1:0]         hit_vec,
    output logic                  present,
    output logic [SW-1:0]         sect
);
    for (genvar g = 0; g < NS; g++) begin : g_cmp
        assign hit_vec[g] = sect_valid[g] && (tags[g] == look_tag);
    end

    assign present = |hit_vec;

    always_comb begin
        sect = '0;
        for (int i = 0; i < NS; i++) begin
            if (hit_vec[i]) sect = SW'(i);
        end
    end
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
    parameter int NS  = 8,
    localparam int SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch,
    input  logic [SW-1:0] touch_idx,
    input  logic [NS-1:0] lock_mask,
    output logic [SW-1:0] victim_idx,
    output logic          victim_ok
);
    // rank 0 = most recently used, NS-1 = least recently used
    logic [SW-1:0] rank [NS];
    logic [SW-1:0] best;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) rank[i] <= SW'(i);
        end else if (touch) begin
            for (int i = 0; i < NS; i++) begin
                if (SW'(i) == touch_idx) rank[i] <= '0;
                else if (rank[i] < rank[touch_idx]) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_ok  = 1'b0;
        victim_idx = '0;
        best       = '0;
        for (int i = 0; i < NS; i++) begin
            if (!lock_mask[i] && (!victim_ok || rank[i] > best)) begin
                victim_ok  = 1'b1;
                victim_idx = SW'(i);
                best       = rank[i];
            end
        end
    end
endmodule

// File: rtl/icache_lockable.sv
module icache_lockable
    import icache_pkg::*;
#(
    parameter int DW  = icache_pkg::DATA_W,
    parameter int AW  = icache_pkg::ADDR_W,
    parameter int NS  = icache_pkg::NUM_SECT,
    parameter int SWD = icache_pkg::SECT_WORDS,
    localparam int OW = $clog2(SWD),
    localparam int SW = $clog2(NS),
    localparam int IW = idx_bits(NS, SWD),
    localparam int TW = AW - OW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cache_en,
    input  logic          flush,
    input  logic [NS-1:0] lock_mask,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_rdy,
    output logic          fetch_valid,
    output logic [DW-1:0] fetch_data,
    output logic          ext_req,
    output logic [AW-1:0] ext_addr,
    input  logic          ext_ack,
    input  logic [DW-1:0] ext_data,
    input  logic          load_we,
    input  logic [IW-1:0] load_addr,
    input  logic [DW-1:0] load_data
);
    fill_state_t           state;
    logic [NS-1:0][TW-1:0] tags;
    logic [NS-1:0]         sect_valid;
    logic [SWD-1:0]        word_valid [NS];
    logic [AW-1:0]         miss_addr;
    logic [SW-1:0]         fill_sect;
    logic                  fill_keep;
    logic                  use_ext;
    logic [DW-1:0]         ext_q;
    logic [DW-1:0]         arr_q;

    logic [TW-1:0]   req_tag;
    logic [OW-1:0]   req_off;
    logic [NS-1:0]   hit_vec;
    logic            present;
    logic [SW-1:0]   sect;
    logic [SW-1:0]   victim_idx;
    logic            victim_ok;
    logic            accept;
    logic            word_hit;
    logic            cache_hit;
    logic            cache_miss;
    logic            alloc;
    logic            touch;
    logic            fill_done;
    logic            st_we;
    logic [IW-1:0]   st_waddr;
    logic [DW-1:0]   st_wdata;
    logic [IW-1:0]   st_raddr;

    assign req_tag = fetch_addr[AW-1:OW];
    assign req_off = fetch_addr[OW-1:0];

    icache_tag_match #(.NS(NS), .TW(TW)) u_match (
        .tags      (tags),
        .sect_valid(sect_valid),
        .look_tag  (req_tag),
        .hit_vec   (hit_vec),
        .present   (present),
        .sect      (sect)
    );

    assign fetch_rdy  = (state == ST_IDLE);
    assign accept     = fetch_req && fetch_rdy;
    assign word_hit   = present && word_valid[sect][req_off];
    assign cache_hit  = accept && cache_en && word_hit;
    assign cache_miss = accept && cache_en && !word_hit;
    assign alloc      = cache_miss && !present && victim_ok;
    assign touch      = accept && cache_en && (present || victim_ok);
    assign fill_done  = (state == ST_FILL) && ext_ack;

    icache_lru #(.NS(NS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch     (touch),
        .touch_idx (present ? sect : victim_idx),
        .lock_mask (lock_mask),
        .victim_idx(victim_idx),
        .victim_ok (victim_ok)
    );

    always_comb begin
        st_we    = 1'b0;
        st_waddr = load_addr;
        st_wdata = load_data;
        if (fill_done && fill_keep) begin
            st_we    = 1'b1;
            st_waddr = {fill_sect, miss_addr[OW-1:0]};
            st_wdata = ext_data;
        end else if (load_we && !cache_en) begin
            st_we = 1'b1;
        end
        st_raddr = cache_en ? {sect, req_off} : fetch_addr[IW-1:0];
    end

    icache_store #(.DW(DW), .DEPTH(NS * SWD)) u_store (
        .clk  (clk),
        .we   (st_we),
        .waddr(st_waddr),
        .wdata(st_wdata),
        .re   (accept),
        .raddr(st_raddr),
        .rdata(arr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            sect_valid  <= '0;
            tags        <= '0;
            miss_addr   <= '0;
            fill_sect   <= '0;
            fill_keep   <= 1'b0;
            use_ext     <= 1'b0;
            ext_q       <= '0;
            fetch_valid <= 1'b0;
            for (int s = 0; s < NS; s++) word_valid[s] <= '0;
        end else begin
            fetch_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept && (!cache_en || cache_hit)) begin
                        fetch_valid <= 1'b1;
                        use_ext     <= 1'b0;
                    end else if (cache_miss) begin
                        state     <= ST_FILL;
                        miss_addr <= fetch_addr;
                        fill_sect <= present ? sect : victim_idx;
                        fill_keep <= present || victim_ok;
                        if (alloc) begin
                            tags[victim_idx]       <= req_tag;
                            sect_valid[victim_idx] <= 1'b1;
                            word_valid[victim_idx] <= '0;
                        end
                    end
                end
                ST_FILL: begin
                    if (ext_ack) begin
                        state       <= ST_IDLE;
                        fetch_valid <= 1'b1;
                        use_ext     <= 1'b1;
                        ext_q       <= ext_data;
                        if (fill_keep)
                            word_valid[fill_sect][miss_addr[OW-1:0]] <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (flush) begin
                sect_valid <= '0;
                for (int s = 0; s < NS; s++) word_valid[s] <= '0;
            end
        end
    end

    assign ext_req    = (state == ST_FILL);
    assign ext_addr   = miss_addr;
    assign fetch_data = use_ext ? ext_q : arr_q;
endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
    parameter int AW = 16,
    parameter int NS = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cache_en,
    input logic          fetch_req,
    input logic          fetch_rdy,
    input logic          fetch_valid,
    input logic          ext_req,
    input logic [AW-1:0] ext_addr,
    input logic          ext_ack,
    input logic [NS-1:0] hit_vec
);
    a_r3_stall_while_fill: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> !fetch_rdy);

    a_r3_request_held: assert property (@(posedge clk) disable iff (rst)
        ext_req && !ext_ack |=> ext_req && $stable(ext_addr));

    a_r3_release_after_ack: assert property (@(posedge clk) disable iff (rst)
        ext_req && ext_ack |=> fetch_rdy && fetch_valid);

    a_r2_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> $past(ext_req && ext_ack) || $past(fetch_req && fetch_rdy));

    a_r9_ram_direct_read: assert property (@(posedge clk) disable iff (rst)
        fetch_req && fetch_rdy && !cache_en |=> fetch_valid && !ext_req);

    a_r5_single_sector_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

bind icache_lockable icache_chk #(.AW(AW), .NS(NS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cache_en   (cache_en),
    .fetch_req  (fetch_req),
    .fetch_rdy  (fetch_rdy),
    .fetch_valid(fetch_valid),
    .ext_req    (ext_req),
    .ext_addr   (ext_addr),
    .ext_ack    (ext_ack),
    .hit_vec    (hit_vec)
);

// File: tb/icache_lockable_tb_top.sv
module icache_lockable_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_en = 1'b1;
    logic        flush_tb = 1'b0;
    logic        flush_r = 1'b0;
    logic        flush;
    logic [7:0]  lock_mask = 8'h00;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_rdy;
    logic        fetch_valid;
    logic [23:0] fetch_data;
    logic        ext_req;
    logic [15:0] ext_addr;
    logic        ext_ack = 1'b0;
    logic [23:0] ext_data = '0;
    logic        load_we = 1'b0;
    logic [9:0]  load_addr = '0;
    logic [23:0] load_data = '0;

    int total = 0;
    int bad = 0;
    int fills = 0;
    int lat_cfg = 0;
    int wait_cnt = 0;
    bit flush_on_ack = 1'b0;
    bit last_hit;
    logic [23:0] exp_q [$];
    string       rq_q [$];

    assign flush = flush_tb | flush_r;

    always #(CLK_PERIOD / 2) clk = ~clk;

    icache_lockable dut_i (
        .clk(clk), .rst(rst), .cache_en(cache_en), .flush(flush),
        .lock_mask(lock_mask), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdy(fetch_rdy), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_data(ext_data),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data)
    );

    function automatic logic [23:0] ext_word(input logic [15:0] a);
        return {a[15:8] ^ 8'hC3, a};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // external memory model with programmable latency
    always @(negedge clk) begin
        if (ext_ack) begin
            ext_ack = 1'b0;
            flush_r = 1'b0;
        end else if (!rst && ext_req) begin
            if (wait_cnt >= lat_cfg) begin
                ext_ack  = 1'b1;
                ext_data = ext_word(ext_addr);
                flush_r  = flush_on_ack;
                fills++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin : mon
        logic [23:0] e;
        string r;
        if (!rst && fetch_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected word", int'(fetch_data), 0);
            end else begin
                e = exp_q.pop_front();
                r = rq_q.pop_front();
                chk(fetch_data == e, r, "returned word", int'(fetch_data), int'(e));
            end
        end
    end

    // mode: 0 expect miss, 1 expect hit, 2 either
    task automatic fetch(input logic [15:0] a, input logic [23:0] e,
                         input int mode, input string rq);
        int f0;
        @(negedge clk);
        while (!fetch_rdy) @(negedge clk);
        f0 = fills;
        fetch_req  = 1'b1;
        fetch_addr = a;
        exp_q.push_back(e);
        rq_q.push_back(rq);
        @(negedge clk);
        fetch_req = 1'b0;
        last_hit  = fetch_valid;
        if (mode == 1) begin
            chk(fetch_valid == 1'b1, rq, "hit valid next cycle", int'(fetch_valid), 1);
            chk(fills == f0, rq, "no external read on hit", fills - f0, 0);
        end else if (mode == 0) begin
            chk(!fetch_rdy && ext_req, rq, "miss stalls and requests", int'(ext_req), 1);
            chk(ext_addr == a, rq, "external address", int'(ext_addr), int'(a));
        end
        if (!fetch_valid) begin
            while (!fetch_valid) @(negedge clk);
            if (mode == 0) begin
                chk(fills == f0 + 1, rq, "one external read", fills - f0, 1);
                chk(fetch_rdy == 1'b1, rq, "ready after fill", int'(fetch_rdy), 1);
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_tb = 1'b1;
        @(negedge clk);
        flush_tb = 1'b0;
    endtask

    task automatic load(input logic [9:0] i, input logic [23:0] d);
        @(negedge clk);
        load_we   = 1'b1;
        load_addr = i;
        load_data = d;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int tl [8] = '{0, 1, 3, 4, 5, 6, 7, 8};
        int hits;
        repeat (3) @(negedge clk);
        chk(fetch_rdy && !fetch_valid && !ext_req, "R1", "state in reset",
            {fetch_rdy, fetch_valid, ext_req}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(fetch_rdy && !fetch_valid && !ext_req, "R1", "state after reset",
            {fetch_rdy, fetch_valid, ext_req}, 3'b100);

        // R3 / R2 basic miss then hit
        lat_cfg = 2;
        fetch(16'h0010, ext_word(16'h0010), 0, "R3");
        fetch(16'h0010, ext_word(16'h0010), 1, "R2");

        // R4 partial fill in resident sector
        fetch(16'h0011, ext_word(16'h0011), 0, "R4");
        fetch(16'h0010, ext_word(16'h0010), 1, "R4");
        fetch(16'h0011, ext_word(16'h0011), 1, "R4");

        // R3 latency variants
        lat_cfg = 0;
        fetch(16'h2345, ext_word(16'h2345), 0, "R3");
        lat_cfg = 5;
        fetch(16'h2346, ext_word(16'h2346), 0, "R3");
        fetch(16'h2345, ext_word(16'h2345), 1, "R2");

        // R7 flush
        do_flush();
        lat_cfg = 1;
        fetch(16'h0010, ext_word(16'h0010), 0, "R7");
        fetch(16'h2346, ext_word(16'h2346), 0, "R7");

        // R5 LRU replacement
        do_flush();
        for (int t = 0; t < 8; t++)
            fetch(16'(t * 128 + 3), ext_word(16'(t * 128 + 3)), 0, "R5");
        fetch(16'(3), ext_word(16'(3)), 1, "R5");
        fetch(16'(8 * 128 + 3), ext_word(16'(8 * 128 + 3)), 0, "R5");
        fetch(16'(1 * 128 + 3), ext_word(16'(1 * 128 + 3)), 0, "R5");
        fetch(16'(3), ext_word(16'(3)), 1, "R5");
        fetch(16'(8 * 128 + 3), ext_word(16'(8 * 128 + 3)), 1, "R5");
        fetch(16'(3 * 128 + 3), ext_word(16'(3 * 128 + 3)), 1, "R5");

        // R6 all sectors locked
        lock_mask = 8'hFF;
        fetch(16'h7000, ext_word(16'h7000), 0, "R6");
        fetch(16'h7000, ext_word(16'h7000), 0, "R6");
        fetch(16'(3), ext_word(16'(3)), 1, "R6");

        // R6 only sector 0 replaceable
        lock_mask = 8'hFE;
        fetch(16'h7100, ext_word(16'h7100), 0, "R6");
        fetch(16'h7200, ext_word(16'h7200), 0, "R6");
        fetch(16'h7100, ext_word(16'h7100), 0, "R6");
        fetch(16'h7100, ext_word(16'h7100), 1, "R6");
        fetch(16'h7200, ext_word(16'h7200), 0, "R6");
        hits = 0;
        for (int k = 0; k < 8; k++) begin
            fetch(16'(tl[k] * 128 + 3), ext_word(16'(tl[k] * 128 + 3)), 2, "R6");
            hits += int'(last_hit);
        end
        chk(hits == 7, "R6", "locked sectors kept", hits, 7);

        // R8 flush coinciding with fill completion
        lock_mask = 8'h00;
        do_flush();
        flush_on_ack = 1'b1;
        fetch(16'h0400, ext_word(16'h0400), 0, "R8");
        flush_on_ack = 1'b0;
        fetch(16'h0400, ext_word(16'h0400), 0, "R8");
        fetch(16'h0400, ext_word(16'h0400), 1, "R8");

        // R9 program-RAM mode
        cache_en = 1'b0;
        load(10'd5, 24'hABCDEF);
        load(10'd1023, 24'h123456);
        fetch(16'h0005, 24'hABCDEF, 1, "R9");
        fetch(16'h03FF, 24'h123456, 1, "R9");
        fetch(16'hFC05, 24'hABCDEF, 1, "R9");
        cache_en = 1'b1;
        do_flush();
        fetch(16'h0010, ext_word(16'h0010), 0, "R3");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "all results delivered", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule